// File: doc/BRIEF.md
# Key Event Queue with Autorepeat

This block turns the debounced state of an 8x8 key matrix into a stream of one-byte key events that a host drains one at a time. Once per debounce period, a strobe presents a 64-bit pressed/released vector. Every key whose state differs from the previous sample produces an event. The event carries the key number and the direction of the change, and it is placed in a sixteen-entry queue. When several keys change in the same period, their events are emitted one per clock in ascending key order.

While keys stay down and repeating is enabled, the block periodically adds one shared repeat code. It first waits a programmable start delay, then adds the code at a programmable interval. An active-low interrupt tells the host to read. It fires after a programmed number of debounce periods following an event, or when the queue reaches a programmed fill level, whichever happens first. The host pops the head entry with a read strobe. A mode input selects whether that pop also clears the interrupt.

Top module: `kevq_top`

## Requirements
- R1: The queue stores up to 16 event entries and returns them in the order they were accepted.
- R2: The read byte holds the key number in bits 5:0. Bit 6 is 0 for a press and 1 for a release. Bit 7 is 1 only when at least one more entry is stored behind the one shown.
- R3: Input bit k of `key_state` is key k, where k = column*8 + row. For example, row 0 of column 1 is key 8 and row 0 of column 5 is key 40.
- R4: After reset, and whenever the queue is empty, `rd_data` reads 0x3F. After reset, `irq_n` is high.
- R5: All changes found at one `scan_tick` are queued in ascending key-number order, one per clock. They are queued starting the cycle after the strike.
- R6: With `rpt_en` set and at least one key held, the block queues the code 0x7E (bit 6 set, key field 62) after (`rpt_delay`+1)*8 consecutive strikes with no state change. It then queues 0x7E every (`rpt_rate`+1)*4 strikes. Only one code is queued per interval, however many keys are down, and held keys are never re-queued.
- R7: An entry offered while 16 are stored is discarded, and the stored entries are kept.
- R8: With `clr_on_read` high, a pop clears the interrupt.
- R9: With `clr_on_read` low, the interrupt stays asserted across pops. It clears in the cycle after the queue becomes empty.
- R10: With `rel_en` low, releases produce no entry.
- R11: Any change of the key vector, including a release that is not queued, restarts the repeat sequence from the start delay.
- R12: With `irq_cycles` = N (1..31), the interrupt asserts on the N-th strike after the accepted entry that started the timer. Pending time-outs are abandoned if the queue drains first. Zero disables this source.
- R13: With `irq_level` = L (1..7), the interrupt asserts when the stored count reaches 2*L. Zero disables this source. Either source may fire first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_tick | input | 1 | One-cycle strobe marking a debounced sample |
| key_state | input | 64 | Debounced pressed state, bit k is key k |
| rel_en | input | 1 | Queue release events when high |
| rpt_en | input | 1 | Enable autorepeat |
| rpt_delay | input | 4 | Start delay code, (code+1)*8 strikes |
| rpt_rate | input | 3 | Repeat interval code, (code+1)*4 strikes |
| irq_cycles | input | 5 | Time-based interrupt delay in strikes, 0 = off |
| irq_level | input | 3 | Fill threshold / 2, 0 = off |
| clr_on_read | input | 1 | A pop clears the interrupt when high |
| rd_pop | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry with more-data flag, or 0x3F when empty |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The properties assume that strikes are spaced far enough apart for all events of one strike to drain, that is, at least 65 clocks between strikes. They also assume that `key_state` is stable between strikes. Under those assumptions, the repeat code never competes with a key event for the single push slot. The bench spaces every strike by 72 clocks and changes `key_state` only in the cycle of its strike. Configuration inputs are changed only while no strike is pending, so the properties never see a setting change in the middle of an interval.

// File: rtl/kevq_pkg.sv
package kevq_pkg;
  localparam int KEY_W      = 6;
  localparam int ENTRY_W    = KEY_W + 1;
  localparam logic [7:0] EMPTY_BYTE  = 8'h3F;
  localparam logic [ENTRY_W-1:0] RPT_ENTRY = 7'h7E;

  function automatic int rpt_first_len(input logic [3:0] code);
    return (int'(code) + 1) * 8;
  endfunction

  function automatic int rpt_step_len(input logic [2:0] code);
    return (int'(code) + 1) * 4;
  endfunction

  function automatic int fill_thr(input logic [2:0] lvl);
    return int'(lvl) * 2;
  endfunction
endpackage

// File: rtl/kevq_scan.sv
module kevq_scan #(
  parameter int NKEYS = 64,
  parameter int KW    = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_tick,
  input  logic [NKEYS-1:0] key_state,
  input  logic             rel_en,
  output logic             ev_valid,
  output logic [KW:0]      ev_code,
  output logic             scan_change
);
  logic [NKEYS-1:0] prev_q, pend_q, diff, keep;
  logic [KW-1:0]    idx;

  assign diff        = key_state ^ prev_q;
  assign keep        = rel_en ? diff : (diff & key_state);
  assign scan_change = scan_tick && (diff != '0);

  always_comb begin
    idx = '0;
    for (int i = NKEYS - 1; i >= 0; i--)
      if (pend_q[i]) idx = KW'(i);
  end

  assign ev_valid = (pend_q != '0);
  assign ev_code  = {~prev_q[idx], idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else if (scan_tick) begin
      prev_q <= key_state;
      pend_q <= keep;
    end else if (ev_valid) begin
      pend_q <= pend_q & ~(NKEYS'(1) << idx);
    end
  end
endmodule

// File: rtl/kevq_rpt.sv
module kevq_rpt
  import kevq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_tick,
  input  logic       scan_change,
  input  logic       any_held,
  input  logic       rpt_en,
  input  logic [3:0] rpt_delay,
  input  logic [2:0] rpt_rate,
  output logic       rpt_fire
);
  logic [7:0] cnt_q;
  logic       periodic_q;
  logic       active, reached;
  int         target;

  assign target   = periodic_q ? rpt_step_len(rpt_rate) : rpt_first_len(rpt_delay);
  assign active   = rpt_en && any_held && !scan_change;
  assign reached  = (int'(cnt_q) + 1 == target);
  assign rpt_fire = scan_tick && active && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      periodic_q <= 1'b0;
    end else if (scan_tick) begin
      if (!active) begin
        cnt_q      <= '0;
        periodic_q <= 1'b0;
      end else if (reached) begin
        cnt_q      <= '0;
        periodic_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 8'd1;
      end
    end
  end
endmodule

// File: rtl/kevq_fifo.sv
module kevq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 7,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign head    = mem[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/kevq_irq.sv
module kevq_irq
  import kevq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_tick,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] count,
  input  logic [4:0]    irq_cycles,
  input  logic [2:0]    irq_level,
  input  logic          clr_on_read,
  output logic          irq_set,
  output logic          irq_n
);
  logic       run_q, irq_q, lvl_hit, tmr_hit, drained;
  logic [4:0] tcnt_q;

  assign drained = (count == '0) && !push_ok;
  assign lvl_hit = (irq_level != '0) && push_ok && !pop_ok
                   && (int'(count) + 1 == fill_thr(irq_level));
  assign tmr_hit = run_q && scan_tick && (count != '0)
                   && (int'(tcnt_q) + 1 == int'(irq_cycles));
  assign irq_set = lvl_hit || tmr_hit;
  assign irq_n   = ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tcnt_q <= '0;
    end else if (drained || tmr_hit) begin
      run_q  <= 1'b0;
      tcnt_q <= '0;
    end else if (push_ok && !run_q && irq_cycles != '0) begin
      run_q  <= 1'b1;
      tcnt_q <= '0;
    end else if (run_q && scan_tick) begin
      tcnt_q <= tcnt_q + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               irq_q <= 1'b0;
    else if (irq_set)                         irq_q <= 1'b1;
    else if (drained || (clr_on_read && pop_ok)) irq_q <= 1'b0;
  end
endmodule

// File: rtl/kevq_top.sv
module kevq_top
  import kevq_pkg::*;
#(
  parameter int NKEYS = 64,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_tick,
  input  logic [NKEYS-1:0] key_state,
  input  logic             rel_en,
  input  logic             rpt_en,
  input  logic [3:0]       rpt_delay,
  input  logic [2:0]       rpt_rate,
  input  logic [4:0]       irq_cycles,
  input  logic [2:0]       irq_level,
  input  logic             clr_on_read,
  input  logic             rd_pop,
  output logic [7:0]       rd_data,
  output logic             irq_n
);
  logic               ev_valid, scan_change, rpt_fire;
  logic [ENTRY_W-1:0] ev_code, push_data, head;
  logic               push, push_ok, pop_ok, irq_set;
  logic [CW-1:0]      count;

  kevq_scan #(.NKEYS(NKEYS), .KW(KEY_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_state(key_state),
    .rel_en(rel_en), .ev_valid(ev_valid), .ev_code(ev_code),
    .scan_change(scan_change));

  kevq_rpt u_rpt (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .scan_change(scan_change),
    .any_held(|key_state), .rpt_en(rpt_en), .rpt_delay(rpt_delay),
    .rpt_rate(rpt_rate), .rpt_fire(rpt_fire));

  assign push      = ev_valid || rpt_fire;
  assign push_data = ev_valid ? ev_code : RPT_ENTRY;

  kevq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(rd_pop), .head(head), .count(count), .push_ok(push_ok),
    .pop_ok(pop_ok));

  kevq_irq #(.CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .push_ok(push_ok),
    .pop_ok(pop_ok), .count(count), .irq_cycles(irq_cycles),
    .irq_level(irq_level), .clr_on_read(clr_on_read), .irq_set(irq_set),
    .irq_n(irq_n));

  assign rd_data = (count == '0) ? EMPTY_BYTE : {count > CW'(1), head};
endmodule

// File: rtl/kevq_chk.sv
module kevq_chk #(
  parameter int NKEYS = 64,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NKEYS-1:0] key_state,
  input logic             rpt_en,
  input logic             clr_on_read,
  input logic [7:0]       rd_data,
  input logic             irq_n,
  input logic [CW-1:0]    count,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             rpt_fire,
  input logic             irq_set
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (rd_data == 8'h3F)); // R4
  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop_ok) |=> (count == CW'(DEPTH))); // R7
  AST_RPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_fire |-> (rpt_en && (key_state != '0))); // R6
  AST_POP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_read && pop_ok && !irq_set) |=> irq_n); // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push_ok) |=> irq_n); // R9
  AST_SINGLE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1)); // R1
endmodule

bind kevq_top kevq_chk #(.NKEYS(NKEYS), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_state(key_state), .rpt_en(rpt_en),
  .clr_on_read(clr_on_read), .rd_data(rd_data), .irq_n(irq_n),
  .count(count), .push_ok(push_ok), .pop_ok(pop_ok), .rpt_fire(rpt_fire),
  .irq_set(irq_set));

// File: tb/tb_kevq_top.sv
module tb_kevq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_tick = 1'b0;
  logic [63:0] key_state = '0;
  logic        rel_en = 1'b1, rpt_en = 1'b0;
  logic [3:0]  rpt_delay = '0;
  logic [2:0]  rpt_rate = '0;
  logic [4:0]  irq_cycles = '0;
  logic [2:0]  irq_level = '0;
  logic        clr_on_read = 1'b0, rd_pop = 1'b0;
  logic [7:0]  rd_data;
  logic        irq_n;

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [6:0]  mq[$];
  logic [63:0] m_state = '0;
  int          m_cnt = 0;
  bit          m_per = 0;

  always #5 clk = ~clk;

  kevq_top dut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_state(key_state),
    .rel_en(rel_en), .rpt_en(rpt_en), .rpt_delay(rpt_delay),
    .rpt_rate(rpt_rate), .irq_cycles(irq_cycles), .irq_level(irq_level),
    .clr_on_read(clr_on_read), .rd_pop(rd_pop), .rd_data(rd_data),
    .irq_n(irq_n));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_push(input logic [6:0] e);
    if (mq.size() < 16) mq.push_back(e);  // R7 drop when full
  endtask

  // driver: builds expected entries from the requirements, then strikes
  task automatic strike(input logic [63:0] st);
    logic [63:0] d = st ^ m_state;
    bit chg = (d != '0);
    for (int k = 0; k < 64; k++)        // R5 ascending order
      if (d[k] && (rel_en || st[k])) model_push({~st[k], 6'(k)});  // R10
    if (chg || !rpt_en || st == '0) begin  // R11
      m_cnt = 0; m_per = 0;
    end else begin
      m_cnt++;
      if (m_cnt == (m_per ? (int'(rpt_rate) + 1) * 4 : (int'(rpt_delay) + 1) * 8)) begin
        model_push(7'h7E);  // R6
        m_cnt = 0; m_per = 1;
      end
    end
    m_state = st;
    @(negedge clk); key_state = st; scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  // monitor: compares the head against the expected queue and pops it
  task automatic pop_check(input string tag);
    logic [7:0] exp = (mq.size() == 0) ? 8'h3F : {mq.size() > 1, mq[0]};
    check(rd_data, exp, tag);
    rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    while (mq.size() != 0) pop_check(tag);
    check(rd_data, 8'h3F, {tag, " empty"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 8'h3F, "R4 reset read");
    check({7'd0, irq_n}, 8'd1, "R4 reset irq");

    // R3 R5 R2: keys 63, 8 (col1,row0), 3 in one strike
    strike(64'h8000_0000_0000_0108);
    check(rd_data, 8'h83, "R5 R2 first head key3 more");
    drain("R5 R3 R2 order");

    // R10 release ignored, then R2 release bit
    rel_en = 1'b0;
    strike(64'h8000_0000_0000_0100);
    check(rd_data, 8'h3F, "R10 masked release");
    rel_en = 1'b1;
    strike(64'h8000_0000_0000_0000);
    check(rd_data, 8'h48, "R2 release key8");
    drain("R2 release");
    rel_en = 1'b0;
    strike('0);
    rel_en = 1'b1;

    // R7 R1 overflow: 20 keys at once
    strike(64'h0000_00F0_000F_F0FF);
    drain("R7 R1 overflow");
    rel_en = 1'b0;
    strike('0);
    check(rd_data, 8'h3F, "R10 bulk release");
    rel_en = 1'b1;

    // R6 R11 autorepeat
    rpt_en = 1'b1; rpt_delay = 4'd0; rpt_rate = 3'd0;
    strike(64'h20);
    drain("R6 press");
    for (int i = 0; i < 7; i++) strike(64'h20);
    check(rd_data, 8'h3F, "R6 before delay");
    strike(64'h20);
    check(rd_data, 8'h7E, "R6 first repeat");
    for (int i = 0; i < 4; i++) strike(64'h20);
    drain("R6 periodic");
    strike(64'h220);
    drain("R11 new key");
    for (int i = 0; i < 7; i++) strike(64'h220);
    check(rd_data, 8'h3F, "R11 restarted delay");
    strike(64'h220);
    check(rd_data, 8'h7E, "R6 one code two keys");
    drain("R6 two keys");
    strike(64'h200);
    for (int i = 0; i < 8; i++) strike(64'h200);
    drain("R11 after release");
    rpt_en = 1'b0;
    strike('0);
    drain("R6 cleanup");

    // R13 R9 fill-level interrupt, pop does not clear
    irq_level = 3'd1; clr_on_read = 1'b0;
    strike(64'h2);
    check({7'd0, irq_n}, 8'd1, "R13 below level");
    strike(64'h6);
    check({7'd0, irq_n}, 8'd0, "R13 level reached");
    pop_check("R9 pop one");
    check({7'd0, irq_n}, 8'd0, "R9 held across pop");
    pop_check("R9 pop last");
    check({7'd0, irq_n}, 8'd1, "R9 clear on empty");
    irq_level = 3'd0;
    rel_en = 1'b0; strike('0); rel_en = 1'b1;

    // R12 R8 time interrupt, pop clears
    irq_cycles = 5'd3; clr_on_read = 1'b1;
    strike(64'h0000_0100_0000_0000);  // key 40 = col5,row0 R3
    strike(64'h0000_0100_0000_0000);
    strike(64'h0000_0100_0000_0000);
    check({7'd0, irq_n}, 8'd1, "R12 before timeout");
    strike(64'h0000_0100_0000_0000);
    check({7'd0, irq_n}, 8'd0, "R12 timeout");
    check(rd_data, 8'h28, "R3 key40 code");
    pop_check("R8 pop");
    check({7'd0, irq_n}, 8'd1, "R8 cleared by pop");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule